// File: doc/BRIEF.md
# Serial receiver with two-step status clear

The block recovers characters from an asynchronous serial line. A clock-enable input paces it at sixteen samples per bit period. A falling edge on the line starts a frame, but only if the vote taken near the middle of the start bit still reads low. The data bits arrive least significant first, and each bit is decided by a three-sample majority vote near its centre. A mode input chooses 8 or 9 data bits per character. After the data bits comes one stop bit. When the stop bit has been judged, the assembled character moves into a single holding buffer. Five status flags record what happened: buffer full, overrun, noise, framing error and idle line.

Data leaves through a register-style read and not through a valid/ready stream. No back-pressure reaches the line. A character that completes while the buffer is still full is counted as an overrun and is lost, and the buffered character is kept. Software clears the flags in two steps. First a status read is made while any flag is set. Then a data read clears all five flags and consumes the buffer. Two interrupt outputs are combinational. Each one is gated by its own enable input and by a common mask input.

Top module: `serial_rx_status`

## Requirements
- R1: When `word9_mode` is 1, a frame has 9 data bits and the ninth (most significant) bit appears on `rx_bit8`. When it is 0, a frame has 8 data bits and `rx_bit8` reads 0.
- R2: Bits are assembled least significant first. While `rx_enable` is 0, no start bit is searched for and no character is delivered.
- R3: When the stop bit is judged and the buffer is empty, the character is copied to `rx_data`/`rx_bit8` and `rx_full` is set.
- R4: `rx_irq` is high exactly when (`rx_full` or `rx_overrun`) is set, `rx_irq_en` is 1 and `irq_mask` is 0.
- R5: A character that completes while `rx_full` is set raises `rx_overrun`. `rx_data`, `rx_bit8`, `rx_noise` and `rx_frame_err` keep their values.
- R6: A `status_rd` pulse taken while any flag is set, followed later by a `data_rd` pulse, clears `rx_full`, `rx_overrun`, `rx_noise`, `rx_frame_err` and `rx_idle`. The clear shows in the cycle after the data read.
- R7: Each bit takes the majority of samples 7, 8 and 9 of its sixteen. If those three samples disagree in any bit of a frame, `rx_noise` is set together with `rx_full`, and the voted data is still stored.
- R8: A stop bit voted low sets `rx_frame_err` together with `rx_full`, and the data is still stored. A break (line low through the stop bit) therefore gives data 0 with `rx_frame_err` set.
- R9: After a character, if the line stays high for one full frame length (10 or 11 bit periods depending on the mode), `rx_idle` is set once. `idle_irq` is high exactly when `rx_idle`, `idle_irq_en` and not `irq_mask` all hold.
- R10: A falling edge whose start-bit majority reads high is dropped. The receiver goes back to searching and delivers nothing.
- R11: A `data_rd` without an earlier armed status read clears nothing. A `status_rd` made while no flag is set does not arm the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | One pulse per sample, sixteen per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Receiver on |
| word9_mode | input | 1 | 1 selects 9 data bits |
| rx_irq_en | input | 1 | Receive interrupt enable |
| idle_irq_en | input | 1 | Idle interrupt enable |
| irq_mask | input | 1 | Global mask, 1 blocks both interrupts |
| status_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| rx_data | output | 8 | Buffered character, low 8 bits |
| rx_bit8 | output | 1 | Ninth bit of the buffered character |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_overrun | output | 1 | A character was lost while the buffer was full |
| rx_noise | output | 1 | Sample disagreement in the buffered frame |
| rx_frame_err | output | 1 | Stop bit voted low |
| rx_idle | output | 1 | A quiet frame time followed a character |
| rx_irq | output | 1 | Receive interrupt request |
| idle_irq | output | 1 | Idle interrupt request |

## Verification
The line is driven with several kinds of frame:
- Clean 8-bit and 9-bit frames with mixed bit values show whether bit order and ninth-bit placement are right.
- Back-to-back frames with no read in between separate keeping the buffer on overrun from overwriting it.
- A one-sample glitch at mid-bit must set the noise flag while the voted value stays correct.
- A low stop bit and a held break must both set the framing flag.
- A short low pulse on the line must be dropped as a false start.
- Reads in the wrong order, frames sent while disabled and masked interrupts each check that an input with no effect really has none.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;
endpackage

// File: rtl/rxs_sampler.sv
module rxs_sampler
  import rxs_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 rx_line,
  input  logic                 rx_enable,
  input  logic                 word9,
  output logic                 char_done,
  output logic [DATA_BITS:0]   char_word,
  output logic                 char_noise,
  output logic                 char_ferr,
  output logic                 idle_pulse
);
  localparam int WORD_W = DATA_BITS + 1;
  localparam int CNT_W  = $clog2(OVERSAMPLE);
  localparam int IDX_W  = $clog2(DATA_BITS + 3);
  localparam int IDLE_W = $clog2((DATA_BITS + 3) * OVERSAMPLE + 1);
  localparam logic [CNT_W-1:0] TAP_A   = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] TAP_B   = CNT_W'(OVERSAMPLE / 2);
  localparam logic [CNT_W-1:0] TAP_C   = CNT_W'(OVERSAMPLE / 2 + 1);
  localparam logic [CNT_W-1:0] TAP_END = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] STOP_SHORT = IDX_W'(DATA_BITS + 1);
  localparam logic [IDX_W-1:0] STOP_LONG  = IDX_W'(DATA_BITS + 2);
  localparam logic [IDLE_W-1:0] QUIET_SHORT = IDLE_W'((DATA_BITS + 2) * OVERSAMPLE - 1);
  localparam logic [IDLE_W-1:0] QUIET_LONG  = IDLE_W'((DATA_BITS + 3) * OVERSAMPLE - 1);

  // input synchroniser, depth chosen by parameter
  logic [SYNC_STAGES-1:0] sync_q;
  logic line_s;
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rx_line;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
      end
    end
  endgenerate
  assign line_s = sync_q[SYNC_STAGES-1];

  rx_state_e          state;
  logic [CNT_W-1:0]   phase;
  logic [IDX_W-1:0]   slot;
  logic [IDX_W-1:0]   last_slot;
  logic               long_q;
  logic [WORD_W-1:0]  shreg;
  logic               tap_a_q, tap_b_q;
  logic               split_acc;
  logic               line_prev;
  logic               quiet_arm;
  logic [IDLE_W-1:0]  quiet_cnt;
  logic               vote, split;
  logic [IDLE_W-1:0]  quiet_last;

  always_comb begin
    vote  = (tap_a_q & tap_b_q) | (tap_a_q & line_s) | (tap_b_q & line_s);
    split = (tap_a_q ^ tap_b_q) | (tap_b_q ^ line_s);
    quiet_last = word9 ? QUIET_LONG : QUIET_SHORT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      phase      <= '0;
      slot       <= '0;
      last_slot  <= STOP_SHORT;
      long_q     <= 1'b0;
      shreg      <= '0;
      tap_a_q    <= 1'b1;
      tap_b_q    <= 1'b1;
      split_acc  <= 1'b0;
      line_prev  <= 1'b1;
      quiet_arm  <= 1'b0;
      quiet_cnt  <= '0;
      char_done  <= 1'b0;
      char_word  <= '0;
      char_noise <= 1'b0;
      char_ferr  <= 1'b0;
      idle_pulse <= 1'b0;
    end else begin
      char_done  <= 1'b0;
      idle_pulse <= 1'b0;
      if (sample_en) line_prev <= line_s;
      if (!rx_enable) begin
        state     <= ST_HUNT;
        quiet_cnt <= '0;
      end else if (sample_en) begin
        unique case (state)
          ST_HUNT: begin
            if (line_prev && !line_s) begin
              state     <= ST_FRAME;
              phase     <= CNT_W'(1);
              slot      <= '0;
              split_acc <= 1'b0;
              long_q    <= word9;
              last_slot <= word9 ? STOP_LONG : STOP_SHORT;
              quiet_cnt <= '0;
            end else if (line_s) begin
              if (quiet_arm) begin
                if (quiet_cnt == quiet_last) begin
                  idle_pulse <= 1'b1;
                  quiet_arm  <= 1'b0;
                end
                quiet_cnt <= quiet_cnt + 1'b1;
              end
            end else begin
              quiet_cnt <= '0;
            end
          end
          ST_FRAME: begin
            phase <= phase + 1'b1;
            if (phase == TAP_A) tap_a_q <= line_s;
            if (phase == TAP_B) tap_b_q <= line_s;
            if (phase == TAP_C) begin
              if (slot == '0) begin
                split_acc <= split;
                if (vote) state <= ST_HUNT;
              end else if (slot == last_slot) begin
                char_done  <= 1'b1;
                char_word  <= long_q ? shreg : {1'b0, shreg[WORD_W-1:1]};
                char_noise <= split_acc | split;
                char_ferr  <= ~vote;
                state      <= ST_HUNT;
                quiet_arm  <= 1'b1;
                quiet_cnt  <= '0;
              end else begin
                shreg     <= {vote, shreg[WORD_W-1:1]};
                split_acc <= split_acc | split;
              end
            end
            if (phase == TAP_END) slot <= slot + 1'b1;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> !char_done);
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (state == ST_HUNT) && !char_done);
endmodule

// File: rtl/rxs_status.sv
module rxs_status #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 char_done,
  input  logic [DATA_BITS:0]   char_word,
  input  logic                 char_noise,
  input  logic                 char_ferr,
  input  logic                 idle_pulse,
  input  logic                 status_rd,
  input  logic                 data_rd,
  input  logic                 rx_irq_en,
  input  logic                 idle_irq_en,
  input  logic                 irq_mask,
  output logic [DATA_BITS:0]   word_q,
  output logic                 full_q,
  output logic                 ovr_q,
  output logic                 noise_q,
  output logic                 fe_q,
  output logic                 idle_q,
  output logic                 rx_irq,
  output logic                 idle_irq
);
  logic armed_q;
  logic any_flag;
  logic clr;

  assign any_flag = full_q | ovr_q | noise_q | fe_q | idle_q;
  assign clr      = data_rd & armed_q;
  assign rx_irq   = (full_q | ovr_q) & rx_irq_en & ~irq_mask;
  assign idle_irq = idle_q & idle_irq_en & ~irq_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
      fe_q    <= 1'b0;
      idle_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (clr) begin
        full_q  <= 1'b0;
        ovr_q   <= 1'b0;
        noise_q <= 1'b0;
        fe_q    <= 1'b0;
        idle_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (status_rd && any_flag) begin
        armed_q <= 1'b1;
      end
      if (char_done) begin
        if (full_q && !clr) begin
          ovr_q <= 1'b1;
        end else begin
          word_q  <= char_word;
          full_q  <= 1'b1;
          noise_q <= char_noise;
          fe_q    <= char_ferr;
        end
      end
      if (idle_pulse) idle_q <= 1'b1;
    end
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !full_q) |=> full_q);
  assert_keep_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && full_q && !clr) |=> (ovr_q && $stable(word_q)));
  assert_two_step_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !char_done && !idle_pulse) |=> !(full_q | ovr_q | noise_q | fe_q | idle_q));
  assert_lone_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !armed_q && full_q) |=> full_q);
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 rx_line,
  input  logic                 rx_enable,
  input  logic                 word9_mode,
  input  logic                 rx_irq_en,
  input  logic                 idle_irq_en,
  input  logic                 irq_mask,
  input  logic                 status_rd,
  input  logic                 data_rd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_bit8,
  output logic                 rx_full,
  output logic                 rx_overrun,
  output logic                 rx_noise,
  output logic                 rx_frame_err,
  output logic                 rx_idle,
  output logic                 rx_irq,
  output logic                 idle_irq
);
  logic               done;
  logic [DATA_BITS:0] word;
  logic               noise;
  logic               ferr;
  logic               idle_p;
  logic [DATA_BITS:0] held;

  rxs_sampler #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .rx_line   (rx_line),
    .rx_enable (rx_enable),
    .word9     (word9_mode),
    .char_done (done),
    .char_word (word),
    .char_noise(noise),
    .char_ferr (ferr),
    .idle_pulse(idle_p)
  );

  rxs_status #(
    .DATA_BITS(DATA_BITS)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_done  (done),
    .char_word  (word),
    .char_noise (noise),
    .char_ferr  (ferr),
    .idle_pulse (idle_p),
    .status_rd  (status_rd),
    .data_rd    (data_rd),
    .rx_irq_en  (rx_irq_en),
    .idle_irq_en(idle_irq_en),
    .irq_mask   (irq_mask),
    .word_q     (held),
    .full_q     (rx_full),
    .ovr_q      (rx_overrun),
    .noise_q    (rx_noise),
    .fe_q       (rx_frame_err),
    .idle_q     (rx_idle),
    .rx_irq     (rx_irq),
    .idle_irq   (idle_irq)
  );

  assign rx_data = held[DATA_BITS-1:0];
  assign rx_bit8 = held[DATA_BITS];
endmodule

// File: tb/sim_serial_rx_status.sv
module sim_serial_rx_status;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sample_en = 1'b1, rx_line = 1'b1, rx_enable = 1'b0;
  logic word9_mode = 1'b0, rx_irq_en = 1'b0, idle_irq_en = 1'b0, irq_mask = 1'b0;
  logic status_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit8, rx_full, rx_overrun, rx_noise, rx_frame_err, rx_idle, rx_irq, idle_irq;

  serial_rx_status u0 (.*);

  int n_tests = 0, n_fail = 0, stepno = 0;
  string cur_req = "R3";
  // reference model state
  logic [8:0] m_word = '0;
  bit m_full, m_ovr, m_noise, m_fe, m_idle, m_arm;
  bit p_srd, p_drd, idle_arm;
  int done_at = -1, anchor = 0;
  logic [8:0] pend_word;
  bit pend_noise, pend_fe;
  bit finished = 0;

  function automatic int quiet_len();
    return word9_mode ? 176 : 160;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (step %0d)", cur_req, what, act, exp, stepno);
    end
  endtask

  task automatic step(input bit rx, input bit srd, input bit drd);
    @(negedge clk);
    stepno++;
    rx_line = rx; status_rd = srd; data_rd = drd;
    if (p_drd && m_arm) begin
      m_full = 0; m_ovr = 0; m_noise = 0; m_fe = 0; m_idle = 0; m_arm = 0;
    end else if (p_srd && (m_full | m_ovr | m_noise | m_fe | m_idle)) m_arm = 1;
    if (stepno == done_at) begin
      if (m_full) m_ovr = 1;
      else begin m_word = pend_word; m_full = 1; m_noise = pend_noise; m_fe = pend_fe; end
    end
    if (idle_arm && stepno == anchor + quiet_len() + 4) begin m_idle = 1; idle_arm = 0; end
    p_srd = srd; p_drd = drd;
    if (!rx && rx_enable) anchor = stepno;
    #1;
    chk("rx_data", rx_data, m_word[7:0]);
    chk("rx_bit8", rx_bit8, m_word[8]);
    chk("rx_full", rx_full, m_full);
    chk("rx_overrun", rx_overrun, m_ovr);
    chk("rx_noise", rx_noise, m_noise);
    chk("rx_frame_err", rx_frame_err, m_fe);
    chk("rx_idle", rx_idle, m_idle);
    chk("rx_irq R4", rx_irq, (m_full | m_ovr) & rx_irq_en & !irq_mask);
    chk("idle_irq R9", idle_irq, m_idle & idle_irq_en & !irq_mask);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic frame(input int value, input int nbits, input int glitch_b, input bit stop_v);
    bit en;
    en = rx_enable;
    for (int b = 0; b <= nbits + 1; b++) begin
      for (int o = 0; o < 16; o++) begin
        bit v;
        if (b == 0) v = 1'b0;
        else if (b == nbits + 1) v = stop_v;
        else v = 1'(value >> (b - 1));
        if (b == glitch_b && o == 8) v = ~v;
        step(v, 1'b0, 1'b0);
        if (en && b == nbits + 1 && o == 9) begin
          anchor = stepno; idle_arm = 1; done_at = stepno + 4;
          pend_word = 9'(value);
          pend_noise = (glitch_b > 0 && glitch_b <= nbits);
          pend_fe = !stop_v;
        end
      end
    end
  endtask

  task automatic clear_flags();
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    quiet(3);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cur_req = "R3"; // reset state
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    quiet(20);
    cur_req = "R11"; // status read with no flag set must not arm
    step(1'b1, 1'b1, 1'b0);
    quiet(3);
    cur_req = "R2"; // receiver disabled: frame ignored
    frame(8'h5A, 8, -1, 1'b1);
    quiet(20);
    rx_enable = 1'b1; rx_irq_en = 1'b1; idle_irq_en = 1'b1;
    quiet(5);
    cur_req = "R3";
    frame(8'hA5, 8, -1, 1'b1);
    quiet(10);
    cur_req = "R11"; // lone data read leaves flags set
    step(1'b1, 1'b0, 1'b1);
    quiet(3);
    cur_req = "R9";
    quiet(170);
    cur_req = "R6";
    clear_flags();
    cur_req = "R5";
    frame(8'h11, 8, -1, 1'b1);
    frame(8'h22, 8, -1, 1'b1);
    quiet(170);
    clear_flags();
    cur_req = "R7";
    frame(8'h6B, 8, 4, 1'b1);
    quiet(170);
    clear_flags();
    cur_req = "R8";
    frame(8'hC3, 8, -1, 1'b0);
    quiet(170);
    clear_flags();
    cur_req = "R8"; // break: low through stop bit and beyond
    frame(8'h00, 8, -1, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0);
    quiet(180);
    clear_flags();
    cur_req = "R10";
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    quiet(40);
    cur_req = "R1";
    word9_mode = 1'b1;
    quiet(3);
    frame(9'h1A5, 9, -1, 1'b1);
    quiet(190);
    clear_flags();
    frame(9'h0F0, 9, -1, 1'b1);
    quiet(190);
    clear_flags();
    cur_req = "R4";
    word9_mode = 1'b0; irq_mask = 1'b1;
    quiet(3);
    frame(8'h77, 8, -1, 1'b1);
    quiet(170);
    irq_mask = 1'b0; rx_irq_en = 1'b0; idle_irq_en = 1'b0;
    quiet(5);
    clear_flags();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule